// File: doc/BRIEF.md
# Dot-Matrix Character Column Rasterizer

This block draws one character cell on a point-addressed display whose controller sets or clears a single dot per command. A host first loads bitmaps into an internal 128-entry glyph store through a simple write port, one bitmap per character code. It then pulses `start` with a character code and the cell's top-left coordinate. The block reads the bitmap into a shift register, which holds the unpacked image. It then issues every dot of the 9-column by 14-row cell as a separate point command.

Points leave in column-major order. Each column is walked downward from the top, which means the Y address falls by one per point. At the end of a column, Y is restored to the origin row and X moves one to the right. A dot at 1 is sent as a write and a dot at 0 as an erase, so the whole cell is always repainted. Each point is held on a valid/ready handshake until the display controller accepts it. When the last of the 126 points is accepted, a one-cycle `done` pulse marks the end and the block is idle again.

Top module: `char_column_raster`

## Requirements
- R1: After reset, `pt_valid` and `done` are low.
- R2: A cycle with `ld_we` high stores `ld_bits` as the bitmap of code `ld_code`. Bit index c*14+r holds the dot at column c (0 = leftmost) and row r (0 = top). A later run of that code draws this bitmap.
- R3: `start` accepted in idle raises `pt_valid` two clock edges later. The first point is at (`org_x`, `org_y`).
- R4: Within a column, each accepted point is followed by a point with the same X and with Y one lower.
- R5: After the 14th point of a column, the next point has Y equal to `org_y` and X one greater. Columns run left to right.
- R6: `pt_write` is 1 when the current dot is 1 (write) and 0 when the dot is 0 (erase).
- R7: While `pt_valid` is high and `pt_ready` is low, the point fields and `pt_valid` hold steady.
- R8: Exactly 126 points are issued. On the clock edge that accepts the last point, `done` rises for exactly one cycle and `pt_valid` falls.
- R9: X and Y arithmetic wraps modulo 512: X 511 steps to 0, and Y 0 steps to 511.
- R10: `start` is ignored while a character is being fetched or drawn. The current point sequence and its total count are unchanged.
- R11: Once fetched, the bitmap being drawn is not affected by writes to the glyph store during drawing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Glyph store write enable |
| ld_code | input | 7 | Glyph store write address (character code) |
| ld_bits | input | 126 | Bitmap to store |
| start | input | 1 | Begin drawing a character |
| char_code | input | 7 | Character to draw |
| org_x | input | 9 | Top-left X of the cell |
| org_y | input | 9 | Top-left Y of the cell |
| pt_ready | input | 1 | Display controller accepts the current point |
| pt_valid | output | 1 | A point command is presented |
| pt_x | output | 9 | Point X address |
| pt_y | output | 9 | Point Y address |
| pt_write | output | 1 | 1 = write dot, 0 = erase dot |
| done | output | 1 | One-cycle pulse after the last point is accepted |

## Verification
`start` is captured on one edge, which also issues the store read. The bitmap is loaded on the next edge, so `pt_valid` is checked low at the first falling edge after `start` and high at the second. After that, every accepting edge moves the output to the next point by the following falling edge, and the bench compares each point there against coordinates and dot values computed from the origin and the bitmap it loaded. During stalls the bench holds `pt_ready` low for two falling edges and checks that nothing moves. `done` is checked high at the falling edge right after the last acceptance and low one cycle later.

// File: rtl/char_raster_pkg.sv
package char_raster_pkg;
  localparam int DEF_COLS    = 9;
  localparam int DEF_ROWS    = 14;
  localparam int DEF_CHARS   = 128;
  localparam int DEF_COORD_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EMIT  = 2'd2
  } rast_state_e;
endpackage

// File: rtl/glyph_store.sv
module glyph_store #(
  parameter int NCHARS = 128,
  parameter int GBITS  = 126,
  localparam int CODE_W = $clog2(NCHARS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [GBITS-1:0]  wr_bits,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_code,
  output logic [GBITS-1:0]  rd_bits
);
  logic [GBITS-1:0] mem_q [NCHARS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_code] <= wr_bits;
  end

  // registered read port: data is valid the cycle after rd_en
  always_ff @(posedge clk) begin
    if (rd_en) rd_bits <= mem_q[rd_code];
  end
endmodule

// File: rtl/glyph_shifter.sv
module glyph_shifter #(
  parameter int GBITS = 126
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GBITS-1:0] load_bits,
  input  logic             shift,
  output logic             cur_bit
);
  logic [GBITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sh_q <= '0;
    else if (load)   sh_q <= load_bits;
    else if (shift)  sh_q <= {1'b0, sh_q[GBITS-1:1]};
  end

  assign cur_bit = sh_q[0];

  // R6: the dot presented next is the one that was second in line
  a_r6_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> (cur_bit == $past(sh_q[1])));
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import char_raster_pkg::*;
#(
  parameter int COLS    = 9,
  parameter int ROWS    = 14,
  parameter int COORD_W = 9,
  parameter int CODE_W  = 7,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CODE_W-1:0]  code,
  input  logic [COORD_W-1:0] org_x,
  input  logic [COORD_W-1:0] org_y,
  input  logic               pt_ready,
  output logic               rd_en,
  output logic [CODE_W-1:0]  rd_code,
  output logic               load,
  output logic               shift,
  output logic               pt_valid,
  output logic [COORD_W-1:0] pt_x,
  output logic [COORD_W-1:0] pt_y,
  output logic               done
);
  rast_state_e        state_q;
  logic [COL_W-1:0]   col_q;
  logic [ROW_W-1:0]   row_q;
  logic [COORD_W-1:0] x_q, y_q, top_y_q;
  logic               done_q;

  // coordinate arithmetic, modulo 2**COORD_W
  function automatic logic [COORD_W-1:0] step_down(input logic [COORD_W-1:0] y);
    return y - COORD_W'(1);
  endfunction

  function automatic logic [COORD_W-1:0] step_right(input logic [COORD_W-1:0] x);
    return x + COORD_W'(1);
  endfunction

  // named events
  logic accept_w, hs_w, col_end_w, last_pt_w;
  assign accept_w  = (state_q == ST_IDLE) && start;
  assign hs_w      = (state_q == ST_EMIT) && pt_ready;
  assign col_end_w = (row_q == ROW_W'(ROWS - 1));
  assign last_pt_w = col_end_w && (col_q == COL_W'(COLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      row_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      top_y_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= hs_w && last_pt_w;
      unique case (state_q)
        ST_IDLE: if (start) begin
          x_q     <= org_x;
          y_q     <= org_y;
          top_y_q <= org_y;
          col_q   <= '0;
          row_q   <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_EMIT;
        ST_EMIT: if (hs_w) begin
          if (col_end_w) begin
            row_q <= '0;
            y_q   <= top_y_q;
            if (last_pt_w) begin
              state_q <= ST_IDLE;
            end else begin
              col_q <= col_q + COL_W'(1);
              x_q   <= step_right(x_q);
            end
          end else begin
            row_q <= row_q + ROW_W'(1);
            y_q   <= step_down(y_q);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en    = accept_w;
  assign rd_code  = code;
  assign load     = (state_q == ST_FETCH);
  assign shift    = hs_w;
  assign pt_valid = (state_q == ST_EMIT);
  assign pt_x     = x_q;
  assign pt_y     = y_q;
  assign done     = done_q;

  // R1: nothing presented right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> (!pt_valid && !done));

  // R7: a stalled point holds still
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_valid && !pt_ready) |=> (pt_valid && $stable(pt_x) && $stable(pt_y)));

  // R4 / R9: next point in a column is one lower, wrapping
  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_w && !col_end_w) |=> (pt_y == $past(pt_y) - COORD_W'(1)) && $stable(pt_x));

  // R5 / R9: column change moves right and restores the top row
  a_r5_next_col: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_w && col_end_w && !last_pt_w) |=>
      (pt_x == $past(pt_x) + COORD_W'(1)) && (pt_y == top_y_q));

  // R8: done is a single-cycle pulse with the output quiet
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pt_valid && $past(hs_w)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: start during a run does not restart it
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EMIT) && start && !hs_w) |=> (pt_valid && $stable(pt_x) && $stable(pt_y)));
endmodule

// File: rtl/char_column_raster.sv
module char_column_raster
  import char_raster_pkg::*;
#(
  parameter int GLYPH_COLS = DEF_COLS,
  parameter int GLYPH_ROWS = DEF_ROWS,
  parameter int NUM_CHARS  = DEF_CHARS,
  parameter int COORD_W    = DEF_COORD_W,
  localparam int GLYPH_BITS = GLYPH_COLS * GLYPH_ROWS,
  localparam int CODE_W     = $clog2(NUM_CHARS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_we,
  input  logic [CODE_W-1:0]     ld_code,
  input  logic [GLYPH_BITS-1:0] ld_bits,
  input  logic                  start,
  input  logic [CODE_W-1:0]     char_code,
  input  logic [COORD_W-1:0]    org_x,
  input  logic [COORD_W-1:0]    org_y,
  input  logic                  pt_ready,
  output logic                  pt_valid,
  output logic [COORD_W-1:0]    pt_x,
  output logic [COORD_W-1:0]    pt_y,
  output logic                  pt_write,
  output logic                  done
);
  logic                  rd_en, load, shift;
  logic [CODE_W-1:0]     rd_code;
  logic [GLYPH_BITS-1:0] rd_bits;

  glyph_store #(.NCHARS(NUM_CHARS), .GBITS(GLYPH_BITS)) u_store (
    .clk(clk), .wr_en(ld_we), .wr_code(ld_code), .wr_bits(ld_bits),
    .rd_en(rd_en), .rd_code(rd_code), .rd_bits(rd_bits)
  );

  glyph_shifter #(.GBITS(GLYPH_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_bits(rd_bits),
    .shift(shift), .cur_bit(pt_write)
  );

  raster_seq #(.COLS(GLYPH_COLS), .ROWS(GLYPH_ROWS), .COORD_W(COORD_W), .CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .code(char_code),
    .org_x(org_x), .org_y(org_y), .pt_ready(pt_ready),
    .rd_en(rd_en), .rd_code(rd_code), .load(load), .shift(shift),
    .pt_valid(pt_valid), .pt_x(pt_x), .pt_y(pt_y), .done(done)
  );

  // R8: the shifter is only loaded when the store read has completed
  a_r8_load_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> $past(rd_en));
endmodule

// File: tb/char_column_raster_tb_top.sv
`timescale 1ns/1ps
module char_column_raster_tb_top;
  localparam int NB = 126;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_we = 1'b0;
  logic [6:0]    ld_code = '0;
  logic [NB-1:0] ld_bits = '0;
  logic          start = 1'b0;
  logic [6:0]    char_code = '0;
  logic [8:0]    org_x = '0, org_y = '0;
  logic          pt_ready = 1'b0;
  logic          pt_valid, pt_write, done;
  logic [8:0]    pt_x, pt_y;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  char_column_raster dut_i (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_code(ld_code), .ld_bits(ld_bits),
    .start(start), .char_code(char_code), .org_x(org_x), .org_y(org_y),
    .pt_ready(pt_ready), .pt_valid(pt_valid), .pt_x(pt_x), .pt_y(pt_y),
    .pt_write(pt_write), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NB-1:0] pattern(input int seed);
    logic [NB-1:0] b;
    for (int i = 0; i < NB; i++) b[i] = (((i * 7 + seed * 13) % 5) == 0) ^ (seed[0] & i[0]);
    return b;
  endfunction

  task automatic load_glyph(input int code, input logic [NB-1:0] bits);
    @(negedge clk);
    ld_we = 1'b1; ld_code = 7'(code); ld_bits = bits;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // draw one character and compare every point (R2..R11)
  task automatic draw(input int code, input int ox, input int oy,
                      input logic [NB-1:0] bits, input bit stall, input bit disturb);
    @(negedge clk);
    start = 1'b1; char_code = 7'(code); org_x = 9'(ox); org_y = 9'(oy);
    @(negedge clk);
    start = 1'b0;
    chk(pt_valid == 1'b0, "R3 valid one edge after start", int'(pt_valid), 0);
    @(negedge clk);
    chk(pt_valid == 1'b1, "R3 valid two edges after start", int'(pt_valid), 1);
    for (int p = 0; p < NB; p++) begin
      int c = p / 14;
      int r = p % 14;
      int ex = (ox + c) % 512;
      int ey = (oy - r + 512) % 512;
      chk(pt_valid == 1'b1, "R8 point present", int'(pt_valid), 1);
      chk(int'(pt_x) == ex, (r == 0) ? "R5 column X" : "R4 column X", int'(pt_x), ex);
      chk(int'(pt_y) == ey, (r == 0) ? "R5 top Y" : "R4 Y step", int'(pt_y), ey);
      chk(pt_write == bits[p], "R6 R2 R11 write/erase", int'(pt_write), int'(bits[p]));
      if (stall && (p % 3 == 1)) begin
        pt_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk(pt_valid && int'(pt_x) == ex && int'(pt_y) == ey && pt_write == bits[p],
            "R7 hold under stall", int'(pt_y), ey);
      end
      pt_ready = 1'b1;
      if (disturb && p == 40) begin
        start = 1'b1; char_code = 7'(code ^ 1); org_x = 9'd3; org_y = 9'd3;
      end
      if (disturb && p == 60) begin
        ld_we = 1'b1; ld_code = 7'(code); ld_bits = ~bits;
      end
      @(negedge clk);
      pt_ready = 1'b0; start = 1'b0; ld_we = 1'b0;
    end
    chk(done == 1'b1, "R8 done after last point", int'(done), 1);
    chk(pt_valid == 1'b0, "R8 valid low at done", int'(pt_valid), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    chk(pt_valid == 1'b0, "R10 no restart after run", int'(pt_valid), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(pt_valid == 1'b0, "R1 valid after reset", int'(pt_valid), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pt_valid == 1'b0 && done == 1'b0, "R1 quiet idle", int'(pt_valid), 0);
  endtask

  task automatic t_basic;
    load_glyph(5, pattern(5));
    draw(5, 100, 200, pattern(5), 1'b0, 1'b0);
  endtask

  task automatic t_stall;
    load_glyph(66, pattern(66));
    draw(66, 300, 50, pattern(66), 1'b1, 1'b0);
  endtask

  task automatic t_wrap;
    load_glyph(127, '1);
    draw(127, 507, 5, '1, 1'b0, 1'b0);   // R9 both axes wrap
  endtask

  task automatic t_zeros;
    load_glyph(0, '0);
    draw(0, 0, 0, '0, 1'b1, 1'b0);       // R9 Y 0 -> 511, R6 all erase
  endtask

  task automatic t_busy;
    load_glyph(9, pattern(9));
    load_glyph(8, pattern(77));
    draw(9, 20, 400, pattern(9), 1'b0, 1'b1);  // R10, R11
    draw(9, 20, 400, ~pattern(9), 1'b0, 1'b0); // R2 rewritten bitmap now used
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_stall();
    t_wrap();
    t_zeros();
    t_busy();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule